// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block collects up to eight interrupt request lines and decides which of them the processor should service next. It samples the request lines on each clock, removes the lines that software has masked, and compares the best remaining request with the lines already in service. When a request deserves attention it raises a single interrupt output and presents the 3-bit index of the winning line. An acknowledge from the processor marks that line as in service.

Software controls the block through a small command port. Priority can be fixed, with line 0 first and line 7 last, or rotating, where a serviced line drops to the back of the queue once its handler ends. A special mask setting lets a handler admit lower-priority lines while it is still running. End-of-interrupt commands clear in-service bits, either the most urgent one or a named one. A processor that does not use the interrupt output can poll instead: it reads a status word that shows whether a request is waiting and which line it is.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset the in-service set is empty, no line is masked, priority is fixed, special mask is off, `irq_o` is low and `poll_word_o` is 0x00.
- R2: Request lines are level-sensitive and registered once, so a line that rises is reflected on `irq_o` one clock later. A line that drops before it is acknowledged is not granted.
- R3: With fixed priority, line 0 ranks highest and line 7 lowest, and `vec_o` names the highest-ranked pending unmasked line.
- R4: In nested operation, `irq_o` is high only when the best pending unmasked line ranks strictly above every line in service.
- R5: When `ack_i` is high in a cycle with `irq_o` high, the line on `vec_o` enters service at that clock edge and `irq_o` drops unless another line now qualifies. An acknowledge while `irq_o` is low changes nothing.
- R6: Writing the mask (opcode 1, argument bit i masks line i) stops masked lines from raising `irq_o`, while their in-service bits are kept.
- R7: The any-line end-of-interrupt (opcode 3) clears only the highest-ranked in-service bit. It does nothing when no line is in service.
- R8: The named end-of-interrupt (opcode 4, line in argument bits 2:0) clears that line's in-service bit.
- R9: The mode write (opcode 2) uses argument bit 0 to select rotating priority. In rotating mode every end-of-interrupt makes the cleared line the lowest-ranked, so ranks run round-robin from the line after it. Selecting fixed mode restores line 7 as lowest.
- R10: With special mask on (mode argument bit 1), the highest-ranked line that is unmasked, requesting and not itself in service is granted, whatever else is in service.
- R11: `poll_word_o` carries the same condition as `irq_o` in bit 7 and the winning line in bits 2:0, with all other bits 0. A `poll_i` pulse acts as an acknowledge.
- R12: An acknowledge and an end-of-interrupt in the same cycle both take effect. If both name the same line, the line ends up in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Level interrupt request lines, bit i is line i |
| ack_i | input | 1 | Processor acknowledge of the presented line |
| poll_i | input | 1 | Poll read strobe, acts as an acknowledge |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode: 1 mask, 2 mode, 3 any-line EOI, 4 named EOI |
| cmd_arg_i | input | 8 | Command argument |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Index of the line that would be granted |
| poll_word_o | output | 8 | Poll status word |
| isr_o | output | 8 | In-service set, bit i is line i |

## Verification
An acknowledge, which sets an in-service bit, and an end-of-interrupt command, which clears one, can land in the same clock. The bench puts line 3 in service, raises the higher-ranked line 1, and then in one cycle drives `ack_i` together with a named end-of-interrupt for line 3. It expects the in-service set to hold only line 1. A lost set would leave it empty, and a lost clear would leave both bits set.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_MASK     = 3'd1,
    OP_MODE     = 3'd2,
    OP_EOI_ANY  = 3'd3,
    OP_EOI_LINE = 3'd4
  } irq_op_e;

  localparam int MODE_ROT_BIT = 0;
  localparam int MODE_SMM_BIT = 1;
endpackage

// File: rtl/irq_rank_pick.sv
module irq_rank_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  input  logic [IW-1:0] low_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] rank_o
);
  // line that holds rank k when low is the lowest-ranked line
  function automatic logic [IW-1:0] slot_line(input logic [IW-1:0] low, input int k);
    return IW'((int'(low) + 1 + k) % N);
  endfunction

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (bits_i[slot_line(low_i, k)]) begin
        found_o = 1'b1;
        idx_o   = slot_line(low_i, k);
        rank_o  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr_i,
  input  logic          mode_wr_i,
  input  logic [N-1:0]  arg_i,
  input  logic          rot_in_i,
  input  logic          smm_in_i,
  input  logic          eoi_fire_i,
  input  logic [IW-1:0] eoi_at_i,
  output logic [N-1:0]  mask_q,
  output logic          rot_q,
  output logic          smm_q,
  output logic [IW-1:0] low_q
);
  localparam logic [IW-1:0] LOW_FIXED = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rot_q  <= 1'b0;
      smm_q  <= 1'b0;
      low_q  <= LOW_FIXED;
    end else begin
      if (mask_wr_i) mask_q <= arg_i;
      if (mode_wr_i) begin
        rot_q <= rot_in_i;
        smm_q <= smm_in_i;
      end
      if (mode_wr_i && !rot_in_i) low_q <= LOW_FIXED;
      else if (eoi_fire_i && rot_q) low_q <= eoi_at_i;
    end
  end

  // R9
  fixed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_q |-> low_q == LOW_FIXED);

  // R9
  rotate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire_i && rot_q && !mode_wr_i) |=> low_q == $past(eoi_at_i));
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [IW-1:0] take_idx_i,
  input  logic          eoi_any_i,
  input  logic          eoi_line_i,
  input  logic [IW-1:0] eoi_sel_i,
  input  logic [IW-1:0] low_i,
  output logic [N-1:0]  isr_q,
  output logic          top_found_o,
  output logic [IW-1:0] top_idx_o,
  output logic [IW-1:0] top_rank_o,
  output logic          eoi_fire_o,
  output logic [IW-1:0] eoi_at_o
);
  function automatic logic [N-1:0] bit_at(input logic [IW-1:0] idx);
    logic [N-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  logic [N-1:0] set_vec, clr_vec, isr_d;

  irq_rank_pick #(.N(N), .IW(IW)) u_top_pick (
    .bits_i (isr_q),
    .low_i  (low_i),
    .found_o(top_found_o),
    .idx_o  (top_idx_o),
    .rank_o (top_rank_o)
  );

  assign eoi_fire_o = eoi_line_i || (eoi_any_i && top_found_o);
  assign eoi_at_o   = eoi_line_i ? eoi_sel_i : top_idx_o;
  assign clr_vec    = eoi_fire_o ? bit_at(eoi_at_o) : '0;
  assign set_vec    = take_i ? bit_at(take_idx_i) : '0;
  assign isr_d      = (isr_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  // R5
  isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q & ~$past(isr_q)));

  // R12
  take_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> isr_q[$past(take_idx_i)]);

  // R7
  eoi_any_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_any_i && !eoi_line_i && top_found_o && !take_i)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import irq_resolver_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             ack_i,
  input  logic             poll_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [LINES-1:0] cmd_arg_i,
  output logic             irq_o,
  output logic [$clog2(LINES)-1:0] vec_o,
  output logic [7:0]       poll_word_o,
  output logic [LINES-1:0] isr_o
);
  localparam int IW  = $clog2(LINES);
  localparam int PAD = 7 - IW;

  logic [LINES-1:0] irr_q, mask_q, isr_q, pend, cand;
  logic             rot_q, smm_q;
  logic [IW-1:0]    low_q;
  logic             p_found, top_found, grant, take;
  logic [IW-1:0]    p_idx, p_rank, top_idx, top_rank;
  logic             eoi_fire;
  logic [IW-1:0]    eoi_at;
  logic             mask_wr, mode_wr, eoi_any, eoi_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= req_i;
  end

  assign mask_wr  = cmd_valid_i && (cmd_op_i == OP_MASK);
  assign mode_wr  = cmd_valid_i && (cmd_op_i == OP_MODE);
  assign eoi_any  = cmd_valid_i && (cmd_op_i == OP_EOI_ANY);
  assign eoi_line = cmd_valid_i && (cmd_op_i == OP_EOI_LINE);

  irq_ctrl_regs #(.N(LINES), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr_i (mask_wr),
    .mode_wr_i (mode_wr),
    .arg_i     (cmd_arg_i),
    .rot_in_i  (cmd_arg_i[MODE_ROT_BIT]),
    .smm_in_i  (cmd_arg_i[MODE_SMM_BIT]),
    .eoi_fire_i(eoi_fire),
    .eoi_at_i  (eoi_at),
    .mask_q    (mask_q),
    .rot_q     (rot_q),
    .smm_q     (smm_q),
    .low_q     (low_q)
  );

  assign pend = irr_q & ~mask_q;
  assign cand = smm_q ? (pend & ~isr_q) : pend;

  irq_rank_pick #(.N(LINES), .IW(IW)) u_req_pick (
    .bits_i (cand),
    .low_i  (low_q),
    .found_o(p_found),
    .idx_o  (p_idx),
    .rank_o (p_rank)
  );

  assign grant = p_found && (smm_q || !top_found || (p_rank < top_rank));
  assign take  = grant && (ack_i || poll_i);

  irq_service_track #(.N(LINES), .IW(IW)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .take_idx_i (p_idx),
    .eoi_any_i  (eoi_any),
    .eoi_line_i (eoi_line),
    .eoi_sel_i  (cmd_arg_i[IW-1:0]),
    .low_i      (low_q),
    .isr_q      (isr_q),
    .top_found_o(top_found),
    .top_idx_o  (top_idx),
    .top_rank_o (top_rank),
    .eoi_fire_o (eoi_fire),
    .eoi_at_o   (eoi_at)
  );

  assign irq_o       = grant;
  assign vec_o       = p_idx;
  assign poll_word_o = {grant, {PAD{1'b0}}, grant ? p_idx : {IW{1'b0}}};
  assign isr_o       = isr_q;

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !poll_i && !cmd_valid_i) |=> isr_o == $past(isr_o));

  // R6
  masked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mask_q[vec_o] && irr_q[vec_o]);

  // R4
  nested_no_inservice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !smm_q) |-> !isr_o[vec_o]);
endmodule

// File: tb/prio_irq_resolver_test.sv
module prio_irq_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       ack_i = 1'b0;
  logic       poll_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [7:0] cmd_arg_i = '0;
  logic       irq_o;
  logic [2:0] vec_o;
  logic [7:0] poll_word_o;
  logic [7:0] isr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .poll_i(poll_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i),
    .irq_o(irq_o), .vec_o(vec_o), .poll_word_o(poll_word_o), .isr_o(isr_o)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] arg);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_arg_i = arg;
    tick();
    cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_arg_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "irq", irq_o, 0);
    chk("R1", "isr", isr_o, 0);
    chk("R1", "poll", poll_word_o, 0);
  endtask

  task automatic t_nesting();
    req_i = 8'h20; tick();
    chk("R3", "irq line5", irq_o, 1);
    chk("R3", "vec line5", vec_o, 5);
    ack();
    chk("R5", "isr after ack", isr_o, 8'h20);
    chk("R5", "irq after ack", irq_o, 0);
    req_i = 8'h24; tick();
    chk("R4", "preempt irq", irq_o, 1);
    chk("R4", "preempt vec", vec_o, 2);
    ack();
    chk("R5", "isr nested", isr_o, 8'h24);
    req_i = 8'hA4; tick();
    chk("R4", "lower blocked", irq_o, 0);
    cmd(3'd3, 8'h00);
    chk("R7", "eoi any clears top", isr_o, 8'h20);
    chk("R4", "line2 again", vec_o, 2);
    req_i = 8'h00;
    cmd(3'd3, 8'h00);
    chk("R7", "eoi any empties", isr_o, 8'h00);
    cmd(3'd3, 8'h00);
    chk("R7", "eoi any on empty", isr_o, 8'h00);
    chk("R2", "irq idle", irq_o, 0);
    ack();
    chk("R5", "ack without irq", isr_o, 8'h00);
  endtask

  task automatic t_level();
    req_i = 8'h08; tick();
    chk("R2", "irq after rise", irq_o, 1);
    req_i = 8'h00; tick();
    chk("R2", "irq after drop", irq_o, 0);
    ack();
    chk("R2", "dropped not granted", isr_o, 8'h00);
  endtask

  task automatic t_mask();
    cmd(3'd1, 8'h10);
    req_i = 8'h10; tick();
    chk("R6", "masked irq", irq_o, 0);
    chk("R6", "masked poll", poll_word_o, 0);
    cmd(3'd1, 8'h00);
    chk("R6", "unmasked irq", irq_o, 1);
    chk("R6", "unmasked vec", vec_o, 4);
    req_i = 8'h00; tick();
  endtask

  task automatic t_rotate();
    int lowp;
    cmd(3'd2, 8'h01);
    req_i = 8'h10; tick();
    ack();
    cmd(3'd3, 8'h00);
    chk("R9", "isr cleared", isr_o, 0);
    lowp = 4;
    req_i = 8'hFF; tick();
    for (int k = 0; k < 8; k++) begin
      int expv;
      expv = (lowp + 1) % 8;
      chk("R9", "rot irq", irq_o, 1);
      chk("R9", "rot vec", vec_o, expv);
      ack();
      cmd(3'd3, 8'h00);
      lowp = expv;
    end
    req_i = 8'h00;
    cmd(3'd2, 8'h00);
    req_i = 8'h90; tick();
    chk("R9", "fixed restored", vec_o, 4);
    req_i = 8'h00; tick();
  endtask

  task automatic t_smm();
    req_i = 8'h40; tick();
    ack();
    req_i = 8'hC0; tick();
    chk("R4", "line7 blocked", irq_o, 0);
    cmd(3'd2, 8'h02);
    chk("R10", "smm irq", irq_o, 1);
    chk("R10", "smm vec", vec_o, 7);
    cmd(3'd1, 8'h80);
    chk("R6", "smm masked", irq_o, 0);
    chk("R6", "isr kept", isr_o, 8'h40);
    cmd(3'd1, 8'h00);
    ack();
    chk("R10", "smm both in service", isr_o, 8'hC0);
    cmd(3'd3, 8'h00);
    chk("R7", "smm eoi any", isr_o, 8'h80);
    cmd(3'd4, 8'h07);
    chk("R8", "named eoi", isr_o, 8'h00);
    req_i = 8'h00;
    cmd(3'd2, 8'h00);
  endtask

  task automatic t_poll();
    req_i = 8'h48; tick();
    chk("R11", "poll word", poll_word_o, 8'h83);
    poll_i = 1'b1; tick(); poll_i = 1'b0;
    chk("R11", "poll took", isr_o, 8'h08);
    chk("R11", "poll word after", poll_word_o, 8'h00);
    req_i = 8'h4A; tick();
    chk("R12", "vec line1", vec_o, 1);
    ack_i = 1'b1; cmd_valid_i = 1'b1; cmd_op_i = 3'd4; cmd_arg_i = 8'h03;
    tick();
    ack_i = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_arg_i = '0;
    chk("R12", "ack and eoi", isr_o, 8'h02);
    req_i = 8'h00; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_nesting();
    t_level();
    t_mask();
    t_rotate();
    t_smm();
    t_poll();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule